// File: doc/BRIEF.md
# Circular Buffer Index Updater

This block keeps the read or write position of a circular buffer in a DSP loop. It holds one packed control word. The low half of that word is the current index, and the high half is a signed step. A companion limit word supplies the largest legal index. Each update strobe adds the step to the index and writes the result back into the control word. The step half of the word is never changed by an update.

The wrap rule is deliberately simple. It does not compute a remainder. If a forward step goes past the limit, the index restarts at zero. If a backward step goes below zero, the index restarts at the limit.

Software or a sequencer loads the control and limit words once with a load strobe. After that, one update strobe is pulsed for each loop iteration. The control word is always visible on the output.

Top module: `circ_index_unit`

## Requirements
- R1: While reset is asserted (rstN low, asynchronous), the stored control word and the stored limit both become zero, so ctrlOut reads 0.
- R2: A cycle with loadEn high stores ctrlIn and limitIn. ctrlOut shows ctrlIn after that clock edge. When loadEn and stepEn are high in the same cycle, the load wins and no step is applied.
- R3: In a cycle with neither strobe high, the control word and the limit keep their values.
- R4: On an update, the new index (ctrlOut bits 15:0) is the old index plus the step. The step is ctrlOut bits 31:16, read as a two's-complement 16-bit value. This holds when the sum lies between 0 and the limit, both ends included.
- R5: On an update with a positive step, a sum greater than the limit makes the new index 0. A sum exactly equal to the limit is kept. The comparison uses the full sum before it is cut to 16 bits, so a sum above 65535 also wraps to 0.
- R6: On an update with a negative step, a sum below zero makes the new index equal to the limit. A sum of exactly zero is kept.
- R7: An update leaves ctrlOut bits 31:16 (the step) unchanged.
- R8: An update with a step of zero leaves the index unchanged.
- R9: While stepEn stays high without a load, exactly one step is applied on every clock edge.
- R10: The limit is taken from limitIn bits 15:0 only. Bits 31:16 of limitIn have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Load strobe for the control and limit words |
| ctrlIn | input | 32 | Control word to load: step in 31:16, index in 15:0 |
| limitIn | input | 32 | Limit word to load: maximum index in 15:0 |
| stepEn | input | 1 | Update strobe: apply one step |
| ctrlOut | output | 32 | Current control word |

## Verification
The assertions check these rules on every cycle:
- a load captures its input;
- an idle cycle changes nothing;
- an update keeps the step field;
- a zero step is a no-op;
- the direction of each move: a positive step either raises the index or wraps it to zero, and a negative step either lowers it or lands on the limit.

Some behaviour is not visible to those cycle-level rules and is covered only by the bench scenarios. These are the exact values at the wrap boundaries: a sum equal to the limit, a sum of zero, a sum above 65535, and a step of -32768. The bench scenarios also cover load priority over update, and the fact that the upper half of the limit word is ignored.

// File: rtl/circ_idx_pkg.sv
package circ_idx_pkg;
  localparam int IDX_W  = 16;
  localparam int WORD_W = 2 * IDX_W;

  typedef struct packed {
    logic doLoad;
    logic doStep;
  } ctrlStrobes_t;
endpackage

// File: rtl/circ_idx_ctrl.sv
module circ_idx_ctrl
  import circ_idx_pkg::*;
(
  input  logic         loadEn,
  input  logic         stepEn,
  output ctrlStrobes_t strobes
);
  // Load has priority: a simultaneous step request is dropped.
  always_comb begin
    strobes.doLoad = loadEn;
    strobes.doStep = stepEn & ~loadEn;
  end
endmodule

// File: rtl/circ_idx_next.sv
module circ_idx_next #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] curIdx,
  input  logic [IDX_W-1:0] stepVal,
  input  logic [IDX_W-1:0] maxIdx,
  output logic [IDX_W-1:0] nextIdx
);
  // Two guard bits: one for carry past the top, one for the sign.
  localparam int SUM_W = IDX_W + 2;

  logic signed [SUM_W-1:0] idxExt;
  logic signed [SUM_W-1:0] stepExt;
  logic signed [SUM_W-1:0] maxExt;
  logic signed [SUM_W-1:0] rawSum;
  logic stepPos;
  logic stepNeg;
  logic overMax;
  logic underZero;

  always_comb begin
    idxExt    = signed'({2'b00, curIdx});
    stepExt   = signed'({{2{stepVal[IDX_W-1]}}, stepVal});
    maxExt    = signed'({2'b00, maxIdx});
    rawSum    = idxExt + stepExt;
    stepNeg   = stepVal[IDX_W-1];
    stepPos   = ~stepVal[IDX_W-1] & (|stepVal);
    overMax   = rawSum > maxExt;
    underZero = rawSum[SUM_W-1];
    if (stepPos && overMax)
      nextIdx = '0;
    else if (stepNeg && underZero)
      nextIdx = maxIdx;
    else
      nextIdx = rawSum[IDX_W-1:0];
  end
endmodule

// File: rtl/circ_idx_datapath.sv
module circ_idx_datapath
  import circ_idx_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [WW-1:0] ctrlIn,
  input  logic [IW-1:0] maxIn,
  output logic [WW-1:0] ctrlOut
);
  logic [WW-1:0] ctrlReg;
  logic [IW-1:0] maxReg;
  logic [IW-1:0] nextIdx;
  logic [IW-1:0] curIdx;
  logic [IW-1:0] curStep;

  assign curIdx  = ctrlReg[IW-1:0];
  assign curStep = ctrlReg[WW-1:IW];

  circ_idx_next #(.IDX_W(IW)) u_next (
    .curIdx  (curIdx),
    .stepVal (curStep),
    .maxIdx  (maxReg),
    .nextIdx (nextIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      maxReg  <= '0;
    end else if (strobes.doLoad) begin
      ctrlReg <= ctrlIn;
      maxReg  <= maxIn;
    end else if (strobes.doStep) begin
      ctrlReg <= {curStep, nextIdx};
    end
  end

  assign ctrlOut = ctrlReg;

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLoad |=> (ctrlReg == $past(ctrlIn)) && (maxReg == $past(maxIn)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doLoad && !strobes.doStep) |=> $stable(ctrlReg) && $stable(maxReg));

  assert_step_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doStep |=> ctrlReg[WW-1:IW] == $past(ctrlReg[WW-1:IW]));

  assert_fwd_move_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doStep && !ctrlReg[WW-1] && (|ctrlReg[WW-1:IW]))
      |=> (ctrlReg[IW-1:0] == '0) || (ctrlReg[IW-1:0] > $past(ctrlReg[IW-1:0])));

  assert_back_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doStep && ctrlReg[WW-1])
      |=> (ctrlReg[IW-1:0] == $past(maxReg)) || (ctrlReg[IW-1:0] < $past(ctrlReg[IW-1:0])));

  assert_zero_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doStep && (ctrlReg[WW-1:IW] == '0)) |=> $stable(ctrlReg));
endmodule

// File: rtl/circ_index_unit.sv
module circ_index_unit
  import circ_idx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] ctrlIn,
  input  logic [WORD_W-1:0] limitIn,
  input  logic              stepEn,
  output logic [WORD_W-1:0] ctrlOut
);
  ctrlStrobes_t strobes;

  circ_idx_ctrl u_ctrl (
    .loadEn  (loadEn),
    .stepEn  (stepEn),
    .strobes (strobes)
  );

  circ_idx_datapath #(.IW(IDX_W), .WW(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ctrlIn  (ctrlIn),
    .maxIn   (limitIn[IDX_W-1:0]),
    .ctrlOut (ctrlOut)
  );
endmodule

// File: tb/circ_index_unit_test.sv
`timescale 1ns/1ps
module circ_index_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic        stepEn = 1'b0;
  logic [31:0] ctrlIn = '0;
  logic [31:0] limitIn = '0;
  logic [31:0] ctrlOut;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // Reference model state
  int mIdx = 0;
  int mStep = 0;
  int mMax = 0;

  always #2.5 clk = ~clk;

  circ_index_unit uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .ctrlIn(ctrlIn),
    .limitIn(limitIn), .stepEn(stepEn), .ctrlOut(ctrlOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIdx = 0; mStep = 0; mMax = 0;
    end else if (loadEn) begin
      mIdx  = int'(ctrlIn[15:0]);
      mStep = int'($signed(ctrlIn[31:16]));
      mMax  = int'(limitIn[15:0]);
    end else if (stepEn) begin
      int s;
      s = mIdx + mStep;
      if (mStep > 0 && s > mMax) s = 0;
      else if (mStep < 0 && s < 0) s = mMax;
      mIdx = s;
    end
  end

  function automatic logic [31:0] modelWord();
    return {mStep[15:0], mIdx[15:0]};
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (ctrlOut !== modelWord()) begin
        errors++;
        $display("FAIL %s per-cycle: actual %h expected %h", curReq, ctrlOut, modelWord());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic expectWord(input logic [31:0] exp, input string req);
    checks++;
    if (ctrlOut !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, ctrlOut, exp);
    end
  endtask

  task automatic loadWords(input logic [31:0] c, input logic [31:0] l);
    loadEn = 1'b1; ctrlIn = c; limitIn = l;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic stepN(input int n);
    stepEn = 1'b1;
    repeat (n) @(negedge clk);
    stepEn = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    curReq = "R1";
    expectWord(32'h0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectWord(32'h0, "R1");

    curReq = "R2";
    loadWords(32'h0003_0005, 32'd20);
    expectWord(32'h0003_0005, "R2");

    curReq = "R3";
    repeat (3) @(negedge clk);
    expectWord(32'h0003_0005, "R3");

    curReq = "R4";
    stepN(1);
    expectWord(32'h0003_0008, "R4");

    curReq = "R5";
    loadWords(32'h0003_0012, 32'd20);
    stepN(1);
    expectWord(32'h0003_0000, "R5");
    loadWords(32'h0003_0011, 32'd20);
    stepN(1);
    expectWord(32'h0003_0014, "R5");
    loadWords(32'h7FFF_FFF0, 32'h0000_FFFF);
    stepN(1);
    expectWord(32'h7FFF_0000, "R5");

    curReq = "R6";
    loadWords(32'hFFFC_0002, 32'd30);
    stepN(1);
    expectWord(32'hFFFC_001E, "R6");
    loadWords(32'hFFFC_0004, 32'd30);
    stepN(1);
    expectWord(32'hFFFC_0000, "R6");
    loadWords(32'h8000_0000, 32'h0000_1234);
    stepN(1);
    expectWord(32'h8000_1234, "R6");

    curReq = "R7";
    loadWords(32'hFFFB_0063, 32'd200);
    stepN(3);
    expectWord(32'hFFFB_0054, "R7");

    curReq = "R8";
    loadWords(32'h0000_0009, 32'd50);
    stepN(4);
    expectWord(32'h0000_0009, "R8");

    curReq = "R2";
    stepEn = 1'b1; loadEn = 1'b1; ctrlIn = 32'h0002_0007; limitIn = 32'd100;
    @(negedge clk);
    stepEn = 1'b0; loadEn = 1'b0;
    expectWord(32'h0002_0007, "R2");

    curReq = "R9";
    loadWords(32'h0001_0000, 32'd100);
    stepN(4);
    expectWord(32'h0001_0004, "R9");

    curReq = "R10";
    loadWords(32'h0002_000F, 32'hABCD_0010);
    stepN(1);
    expectWord(32'h0002_0000, "R10");

    curReq = "R4";
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 16) == 0)
        loadWords({$urandom_range(0, 65535)} >> 0 & 32'h0000_FFFF | (32'(($urandom % 9) - 4) << 16),
                  32'($urandom_range(0, 40)));
      else begin
        stepEn = ($urandom % 4) != 0;
        @(negedge clk);
        stepEn = 1'b0;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule